// File: doc/BRIEF.md
# Micromirror Array Power Sequencer

This block controls the power enable and the active-low output enable of a micromirror display array so that both follow safe timing on power-up and on shutdown. Every delay is counted in pulses of a free-running one-microsecond tick. The block has its own active-low reset pin, `ext_rst_n`. Once it is out of that reset it drives its power-good control output `pg_ctrl` high. Board logic returns that level on `pwr_ok`. Array power is switched on only after both the reset release and the power-good indication have been seen, whichever of the two arrives later. The output enable is opened after a further delay.

A shutdown request is accepted only while the array is running. On a shutdown the block first closes the output enable. It then runs a fixed preconditioning phase, whose last action is to drop `pg_ctrl`, and then a park phase. After a final power-down delay it removes array power and raises `seq_done`. The sequencer stays in the done state until `ext_rst_n` goes low. A low `ext_rst_n` in any state turns the array off at once. A sticky error flag records a power-good indication that failed to arrive in time.

The default delays are set below the limits they must meet:

| Delay | Default | Limit |
|---|---|---|
| Power enable after both inputs | 100 µs | 150 µs |
| Output enable after power enable | 4000 µs | 5000 µs |
| Preconditioning | 750 µs | 800 µs |
| Park plus power-down delay | 450 µs | 500 µs |

Top module: `mirror_pwr_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, the outputs are `pg_ctrl`=0, `array_pwr_en`=0, `array_oe_n`=1, `seq_done`=0 and `timing_err`=0.
- R2: `pg_ctrl` rises on the first clock edge at which `ext_rst_n` is sampled high while the block is off.
- R3: `array_pwr_en` rises on the clock edge that samples the T_PWREN-th tick after the edge at which `ext_rst_n` and `pwr_ok` are both first seen high. The order in which the two arrive does not matter. A tick sampled at that starting edge does not count.
- R4: `array_oe_n` falls on the edge that samples the T_OEZ-th tick after the edge at which `array_pwr_en` rose.
- R5: `shutdown_req` is acted on only in the running state, after the output enable has been opened. In any other state it changes no output.
- R6: An accepted shutdown raises `array_oe_n` on the next clock edge. `pg_ctrl` then falls on the edge that samples the T_PRE-th tick after that.
- R7: After `pg_ctrl` falls, a park phase of T_PARK ticks and then a delay of T_PD ticks run. On the edge that ends the delay, `array_pwr_en` falls and `seq_done` rises together, with `pg_ctrl` already low.
- R8: `seq_done` holds until `ext_rst_n` is seen low, which clears it on the next edge. A shutdown request has no effect while `seq_done` is high.
- R9: `ext_rst_n` sampled low in any state drives `array_pwr_en`=0, `array_oe_n`=1, `pg_ctrl`=0 and `seq_done`=0 on the next edge. No pending delay completes after that.
- R10: `timing_err` rises on the edge that samples the WD_TICKS-th tick spent waiting for `pwr_ok` after `pg_ctrl` rose. It stays high until `rst`, whatever `ext_rst_n` does.
- R11: `array_oe_n` is never low while `array_pwr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_rst_n | input | 1 | Active-low reset pin of the sequencer |
| pwr_ok | input | 1 | Power-good indication, driven from `pg_ctrl` on the board |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| shutdown_req | input | 1 | Request to start the power-down sequence |
| pg_ctrl | output | 1 | Power-good control output |
| array_pwr_en | output | 1 | Array power enable |
| array_oe_n | output | 1 | Array output enable, active low |
| seq_done | output | 1 | Shutdown sequence complete |
| timing_err | output | 1 | Sticky power-good timeout flag |

## Verification
Each result is due at a known tick count. A power enable, output enable, power-good drop or done edge appears on the edge that samples the N-th tick after its trigger. The outputs that follow a request or an `ext_rst_n` change move on the very next edge, at an unchanged tick count. The bench drives every stimulus at a clock edge where no tick is sampled. It records the tick count at that moment and queues the expected output edges in their fixed detection order, each tagged with the tick count at which it must appear. A monitor compares every observed edge against that queue, and any edge that has no matching entry is a failure. This covers the cases where a request or a pending delay must have no effect.

// File: rtl/mps_pkg.sv
package mps_pkg;

  typedef enum logic [3:0] {
    S_OFF        = 4'd0,
    S_WAIT       = 4'd1,
    S_PWREN_DLY  = 4'd2,
    S_OE_DLY     = 4'd3,
    S_RUN        = 4'd4,
    S_PRECOND    = 4'd5,
    S_PARK       = 4'd6,
    S_PD_DLY     = 4'd7,
    S_DONE       = 4'd8
  } seq_state_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/mps_delay_timer.sv
// Shared phase timer: loaded on phase entry, counts down on each tick.
module mps_delay_timer #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (tick && cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  // The last tick of a phase.
  assign expire = tick && (cnt == CNT_W'(1));

endmodule

// File: rtl/mps_watchdog.sv
// Counts ticks while armed; sets a flag that only rst clears.
module mps_watchdog #(
  parameter int unsigned WD_TICKS = 1000,
  localparam int unsigned WD_W = $clog2(WD_TICKS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic tick,
  output logic err
);

  logic [WD_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      err <= 1'b0;
    end else if (!arm) begin
      cnt <= '0;
    end else if (tick && !err) begin
      if (cnt == WD_W'(WD_TICKS - 1)) begin
        err <= 1'b1;
      end else begin
        cnt <= cnt + WD_W'(1);
      end
    end
  end

endmodule

// File: rtl/mps_ctrl.sv
// Sequencing FSM. Outputs are registered decodes of the next state.
module mps_ctrl
  import mps_pkg::*;
#(
  parameter int unsigned T_PWREN = 100,
  parameter int unsigned T_OEZ   = 4000,
  parameter int unsigned T_PRE   = 750,
  parameter int unsigned T_PARK  = 200,
  parameter int unsigned T_PD    = 250,
  parameter int unsigned CNT_W   = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_rst_n,
  input  logic             pwr_ok,
  input  logic             shutdown_req,
  input  logic             expire,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             wd_arm,
  output logic             pg_ctrl,
  output logic             pwr_en,
  output logic             oe_n,
  output logic             done
);

  seq_state_t state, nxt;

  always_comb begin
    nxt      = state;
    load     = 1'b0;
    load_val = '0;
    case (state)
      S_OFF, S_WAIT: begin
        if (pwr_ok) begin
          nxt      = S_PWREN_DLY;
          load     = 1'b1;
          load_val = CNT_W'(T_PWREN);
        end else begin
          nxt = S_WAIT;
        end
      end
      S_PWREN_DLY: begin
        if (expire) begin
          nxt      = S_OE_DLY;
          load     = 1'b1;
          load_val = CNT_W'(T_OEZ);
        end
      end
      S_OE_DLY: begin
        if (expire) nxt = S_RUN;
      end
      S_RUN: begin
        if (shutdown_req) begin
          nxt      = S_PRECOND;
          load     = 1'b1;
          load_val = CNT_W'(T_PRE);
        end
      end
      S_PRECOND: begin
        if (expire) begin
          nxt      = S_PARK;
          load     = 1'b1;
          load_val = CNT_W'(T_PARK);
        end
      end
      S_PARK: begin
        if (expire) begin
          nxt      = S_PD_DLY;
          load     = 1'b1;
          load_val = CNT_W'(T_PD);
        end
      end
      S_PD_DLY: begin
        if (expire) nxt = S_DONE;
      end
      S_DONE:  nxt = S_DONE;
      default: nxt = S_OFF;
    endcase
    if (!ext_rst_n) begin
      nxt  = S_OFF;
      load = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_OFF;
      pg_ctrl <= 1'b0;
      pwr_en  <= 1'b0;
      oe_n    <= 1'b1;
      done    <= 1'b0;
    end else begin
      state   <= nxt;
      pg_ctrl <= (nxt == S_WAIT) || (nxt == S_PWREN_DLY) || (nxt == S_OE_DLY) ||
                 (nxt == S_RUN)  || (nxt == S_PRECOND);
      pwr_en  <= (nxt == S_OE_DLY) || (nxt == S_RUN) || (nxt == S_PRECOND) ||
                 (nxt == S_PARK)   || (nxt == S_PD_DLY);
      oe_n    <= (nxt != S_RUN);
      done    <= (nxt == S_DONE);
    end
  end

  assign wd_arm = (state == S_WAIT);

endmodule

// File: rtl/mirror_pwr_seq.sv
module mirror_pwr_seq
  import mps_pkg::*;
#(
  parameter int unsigned T_PWREN  = 100,
  parameter int unsigned T_OEZ    = 4000,
  parameter int unsigned T_PRE    = 750,
  parameter int unsigned T_PARK   = 200,
  parameter int unsigned T_PD     = 250,
  parameter int unsigned WD_TICKS = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_rst_n,
  input  logic pwr_ok,
  input  logic us_tick,
  input  logic shutdown_req,
  output logic pg_ctrl,
  output logic array_pwr_en,
  output logic array_oe_n,
  output logic seq_done,
  output logic timing_err
);

  localparam int unsigned MAX_DLY =
    max2(max2(max2(T_PWREN, T_OEZ), max2(T_PRE, T_PARK)), T_PD);
  localparam int unsigned CNT_W = $clog2(MAX_DLY + 1);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expire;
  logic             wd_arm;

  mps_ctrl #(
    .T_PWREN (T_PWREN),
    .T_OEZ   (T_OEZ),
    .T_PRE   (T_PRE),
    .T_PARK  (T_PARK),
    .T_PD    (T_PD),
    .CNT_W   (CNT_W)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .ext_rst_n    (ext_rst_n),
    .pwr_ok       (pwr_ok),
    .shutdown_req (shutdown_req),
    .expire       (tmr_expire),
    .load         (tmr_load),
    .load_val     (tmr_val),
    .wd_arm       (wd_arm),
    .pg_ctrl      (pg_ctrl),
    .pwr_en       (array_pwr_en),
    .oe_n         (array_oe_n),
    .done         (seq_done)
  );

  mps_delay_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .tick     (us_tick),
    .expire   (tmr_expire)
  );

  mps_watchdog #(
    .WD_TICKS (WD_TICKS)
  ) u_wd (
    .clk  (clk),
    .rst  (rst),
    .arm  (wd_arm),
    .tick (us_tick),
    .err  (timing_err)
  );

endmodule

// File: rtl/mirror_pwr_seq_chk.sv
module mirror_pwr_seq_chk (
  input logic clk,
  input logic rst,
  input logic ext_rst_n,
  input logic pg_ctrl,
  input logic array_pwr_en,
  input logic array_oe_n,
  input logic seq_done,
  input logic timing_err
);

  AST_PG_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $rose(pg_ctrl) |-> $past(ext_rst_n)); // R2

  AST_PWREN_WITH_PG: assert property (@(posedge clk) disable iff (rst)
    $rose(array_pwr_en) |-> pg_ctrl); // R3

  AST_PG_LOW_AT_PWROFF: assert property (@(posedge clk) disable iff (rst)
    $fell(array_pwr_en) |-> !pg_ctrl); // R7

  AST_DONE_SAFE: assert property (@(posedge clk) disable iff (rst)
    seq_done |-> (!array_pwr_en && !pg_ctrl && array_oe_n)); // R8

  AST_PIN_RESET_SAFE: assert property (@(posedge clk) disable iff (rst)
    !ext_rst_n |=> (!array_pwr_en && array_oe_n && !pg_ctrl && !seq_done)); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    timing_err |=> timing_err); // R10

  AST_OE_NEEDS_PWR: assert property (@(posedge clk) disable iff (rst)
    !array_oe_n |-> array_pwr_en); // R11

endmodule

bind mirror_pwr_seq mirror_pwr_seq_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .ext_rst_n    (ext_rst_n),
  .pg_ctrl      (pg_ctrl),
  .array_pwr_en (array_pwr_en),
  .array_oe_n   (array_oe_n),
  .seq_done     (seq_done),
  .timing_err   (timing_err)
);

// File: tb/tb_mirror_pwr_seq.sv
`timescale 1ns/1ps
module tb_mirror_pwr_seq;

  localparam int T_PWREN = 3;
  localparam int T_OEZ   = 5;
  localparam int T_PRE   = 8;
  localparam int T_PARK  = 4;
  localparam int T_PD    = 6;
  localparam int WD      = 10;

  // Event ids, in the order the monitor detects them within a cycle.
  localparam int EV_PG_RISE    = 0;
  localparam int EV_PWR_RISE   = 1;
  localparam int EV_OE_FALL    = 2;
  localparam int EV_OE_RISE    = 3;
  localparam int EV_PG_FALL    = 4;
  localparam int EV_PWR_FALL   = 5;
  localparam int EV_DONE_RISE  = 6;
  localparam int EV_DONE_FALL  = 7;
  localparam int EV_ERR_RISE   = 8;
  localparam int NEV           = 9;

  typedef struct {
    int    id;
    int    t;
    string req;
  } exp_item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_rst_n = 1'b0;
  logic pwr_ok = 1'b0;
  logic us_tick = 1'b0;
  logic shutdown_req = 1'b0;
  logic pg_ctrl, array_pwr_en, array_oe_n, seq_done, timing_err;

  int n_checks = 0;
  int n_errors = 0;
  int tick_n   = 0;
  int cyc      = 0;
  bit mon_en   = 1'b0;
  exp_item_t sb_q[$];

  logic p_pg, p_pwr, p_oe_n, p_done, p_err;
  logic [NEV-1:0] ev;

  always #2 clk = ~clk;

  mirror_pwr_seq #(
    .T_PWREN (T_PWREN), .T_OEZ (T_OEZ), .T_PRE (T_PRE),
    .T_PARK (T_PARK), .T_PD (T_PD), .WD_TICKS (WD)
  ) dut (
    .clk (clk), .rst (rst), .ext_rst_n (ext_rst_n), .pwr_ok (pwr_ok),
    .us_tick (us_tick), .shutdown_req (shutdown_req), .pg_ctrl (pg_ctrl),
    .array_pwr_en (array_pwr_en), .array_oe_n (array_oe_n),
    .seq_done (seq_done), .timing_err (timing_err)
  );

  // Tick: one cycle in four, changed at the falling edge.
  always @(negedge clk) begin
    cyc <= cyc + 1;
    us_tick <= ((cyc % 4) == 3);
  end

  always @(posedge clk) if (us_tick) tick_n <= tick_n + 1;

  function automatic string req_of(input int id);
    case (id)
      EV_PG_RISE:   return "R2";
      EV_PWR_RISE:  return "R3";
      EV_OE_FALL:   return "R4";
      EV_OE_RISE:   return "R6";
      EV_PG_FALL:   return "R6";
      EV_PWR_FALL:  return "R7";
      EV_DONE_RISE: return "R7";
      EV_DONE_FALL: return "R8";
      default:      return "R10";
    endcase
  endfunction

  task automatic push(input int id, input int t, input string req);
    exp_item_t it;
    it.id = id; it.t = t; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Move to a point just after a falling edge whose next rising edge samples no tick.
  task automatic safe_point();
    do begin
      @(negedge clk);
      #1;
    end while (us_tick);
  endtask

  task automatic wait_tick(input int n);
    while (tick_n < n) @(negedge clk);
  endtask

  // Monitor: detect output edges and compare with the scoreboard.
  always @(negedge clk) begin
    ev[EV_PG_RISE]   = pg_ctrl && !p_pg;
    ev[EV_PWR_RISE]  = array_pwr_en && !p_pwr;
    ev[EV_OE_FALL]   = !array_oe_n && p_oe_n;
    ev[EV_OE_RISE]   = array_oe_n && !p_oe_n;
    ev[EV_PG_FALL]   = !pg_ctrl && p_pg;
    ev[EV_PWR_FALL]  = !array_pwr_en && p_pwr;
    ev[EV_DONE_RISE] = seq_done && !p_done;
    ev[EV_DONE_FALL] = !seq_done && p_done;
    ev[EV_ERR_RISE]  = timing_err && !p_err;
    if (mon_en) begin
      for (int i = 0; i < NEV; i++) begin
        if (ev[i]) begin
          if (sb_q.size() == 0) begin
            n_checks++;
            n_errors++;
            $display("FAIL %s: unexpected event %0d at tick %0d, expected none",
                     req_of(i), i, tick_n);
          end else begin
            exp_item_t it;
            it = sb_q.pop_front();
            check(it.id == i && it.t == tick_n, it.req, i * 1000 + tick_n,
                  it.id * 1000 + it.t);
          end
        end
      end
    end
    p_pg = pg_ctrl; p_pwr = array_pwr_en; p_oe_n = array_oe_n;
    p_done = seq_done; p_err = timing_err;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    int k;
    repeat (5) @(negedge clk);
    // R1: reset values while rst is held
    check(!pg_ctrl && !array_pwr_en && array_oe_n && !seq_done && !timing_err,
          "R1", {pg_ctrl, array_pwr_en, array_oe_n, seq_done, timing_err}, 5'b00100);
    rst = 1'b0;
    @(negedge clk);
    check(!pg_ctrl && !array_pwr_en && array_oe_n && !seq_done && !timing_err,
          "R1", {pg_ctrl, array_pwr_en, array_oe_n, seq_done, timing_err}, 5'b00100);
    mon_en = 1'b1;

    // R2 / R10 / R5: release pin without power-good; request ignored while waiting
    safe_point();
    k = tick_n;
    ext_rst_n = 1'b1;
    push(EV_PG_RISE, k, "R2");
    push(EV_ERR_RISE, k + WD, "R10");
    wait_tick(k + 2);
    safe_point();
    shutdown_req = 1'b1;
    @(negedge clk);
    shutdown_req = 1'b0;
    wait_tick(k + WD + 2);
    check(array_oe_n && !array_pwr_en, "R5", {array_oe_n, array_pwr_en}, 2'b10);

    // R3 / R4: power-good arrives after release
    safe_point();
    k = tick_n;
    pwr_ok = 1'b1;
    push(EV_PWR_RISE, k + T_PWREN, "R3");
    push(EV_OE_FALL, k + T_PWREN + T_OEZ, "R4");
    wait_tick(k + T_PWREN + T_OEZ + 3);
    check(!array_oe_n && array_pwr_en, "R11", {array_oe_n, array_pwr_en}, 2'b01);
    check(timing_err, "R10", timing_err, 1);

    // R6 / R7: shutdown from the running state
    safe_point();
    k = tick_n;
    shutdown_req = 1'b1;
    push(EV_OE_RISE, k, "R6");
    push(EV_PG_FALL, k + T_PRE, "R6");
    push(EV_PWR_FALL, k + T_PRE + T_PARK + T_PD, "R7");
    push(EV_DONE_RISE, k + T_PRE + T_PARK + T_PD, "R7");
    @(negedge clk);
    shutdown_req = 1'b0;
    wait_tick(k + T_PRE + T_PARK + T_PD + 2);
    // R8: request while done has no effect
    safe_point();
    shutdown_req = 1'b1;
    @(negedge clk);
    shutdown_req = 1'b0;
    wait_tick(tick_n + 2);
    check(seq_done && !array_pwr_en, "R8", {seq_done, array_pwr_en}, 2'b10);

    // R8 / R9: pin reset clears done
    safe_point();
    k = tick_n;
    ext_rst_n = 1'b0;
    push(EV_DONE_FALL, k, "R8");
    wait_tick(k + 2);

    // R3: power-good already present, release comes later
    safe_point();
    k = tick_n;
    ext_rst_n = 1'b1;
    push(EV_PG_RISE, k, "R2");
    push(EV_PWR_RISE, k + T_PWREN, "R3");
    push(EV_OE_FALL, k + T_PWREN + T_OEZ, "R4");
    wait_tick(k + T_PWREN + T_OEZ + 2);

    // R9: pin reset while running
    safe_point();
    k = tick_n;
    ext_rst_n = 1'b0;
    push(EV_OE_RISE, k, "R9");
    push(EV_PG_FALL, k, "R9");
    push(EV_PWR_FALL, k, "R9");
    wait_tick(k + 2);

    // R9: pin reset during the power-enable delay; the delay never completes
    safe_point();
    k = tick_n;
    ext_rst_n = 1'b1;
    push(EV_PG_RISE, k, "R2");
    wait_tick(k + 1);
    safe_point();
    ext_rst_n = 1'b0;
    push(EV_PG_FALL, tick_n, "R9");
    wait_tick(k + T_PWREN + 4);
    check(!array_pwr_en && array_oe_n, "R9", {array_pwr_en, array_oe_n}, 2'b01);

    // R10: only rst clears the error flag
    check(timing_err, "R10", timing_err, 1);
    mon_en = 1'b0;
    safe_point();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!timing_err && !pg_ctrl && array_oe_n, "R10",
          {timing_err, pg_ctrl, array_oe_n}, 3'b001);

    check(sb_q.size() == 0, "R7", sb_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule